// File: doc/BRIEF.md
# Probe Control and Sticky Status Register

This block is the 32-bit control/status word of a debug probe's scan engine. Software changes individual controls without a read-modify-write. A write to the set offset turns on every control bit written as 1. A write to the clear offset turns off every control bit written as 1. The control bits drive the target test-reset line, the open-drain enable of the target system reset, the target power switch, two indicator LEDs and the adaptive-clock enable.

Three asynchronous or engine-side events are latched into sticky flags that read back at the set offset:
- externally sensed system reset,
- target power dropout,
- scan-clock timeout.

The reset-sense and dropout flags follow a sample-and-clear rule. Software writes the flag's bit to the set offset to rearm it, then reads later to learn whether the event happened again. The timeout flag is cleared through the clear offset. The probe's own system-reset drive is masked out of the sensing path. The mask covers the whole time the probe drives the line and a programmable settling window after release.

Top module: `probe_ctl_reg`

## Requirements
- R1: After reset, a read at the set offset (0x10) returns 0x00000008: target power is on, every other control bit is 0, and all flags are 0. The outputs are trst_no=1, srst_oe_no=1, pwr_en_o=1, led_o=0 and adapt_clk_en_o=0.
- R2: A write to offset 0x10 sets each control bit (0, 1, 3, 4, 5, 8) whose data bit is 1. Control bits written as 0 keep their value.
- R3: A write to offset 0x14 clears each control bit (0, 1, 3, 4, 5, 8) whose data bit is 1. Control bits written as 0 keep their value.
- R4: The control outputs follow the control bits as listed below.
  - Bit 0 set drives trst_no low.
  - Bit 1 set drives srst_oe_no low.
  - Bit 3 drives pwr_en_o.
  - Bits 4 and 5 drive led_o[0] and led_o[1].
  - Bit 8 drives adapt_clk_en_o.
- R5: Bit 6 becomes 1 when srst_sense_ni is low long enough to pass the input synchroniser and the probe is not masking. It stays 1 until a write to 0x10 with data bit 6 set.
- R6: Bit 7 becomes 1 when pwr_good_i is low long enough to pass the input synchroniser. It stays 1 until a write to 0x10 with data bit 7 set.
- R7: Bit 10 becomes 1 on any cycle with clk_timeout_i high. It stays 1 until a write to 0x14 with data bit 10 set.
- R8: An event that is active in the same cycle as the write that rearms or clears its flag wins, and the flag stays 1.
- R9: Sensed system reset is ignored while control bit 1 is set and for BLANK_CYC cycles after it is cleared.
- R10: The following have no effect on any bit:
  - writes of bits 2, 9 and 11-31;
  - writes of bits 6/7 to 0x14;
  - writes of bit 10 to 0x10;
  - writes to any other offset.
  
  Unused bits read 0, and reads at any offset other than 0x10 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Write strobe |
| bus_addr_i | input | ADDR_W | Byte offset of the access |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data (combinational on bus_addr_i) |
| srst_sense_ni | input | 1 | Asynchronous sensed level of target system reset, active low |
| pwr_good_i | input | 1 | Asynchronous target power good, low means dropout |
| clk_timeout_i | input | 1 | Synchronous adaptive-clock timeout pulse |
| trst_no | output | 1 | Target test reset, active low |
| srst_oe_no | output | 1 | Open-drain enable for target system reset, low pulls the line |
| pwr_en_o | output | 1 | Target power switch enable |
| led_o | output | 2 | Indicator LEDs |
| adapt_clk_en_o | output | 1 | Adaptive-clock mode enable |

## Verification
The hardest situation to reach is an event that coincides exactly with the write that rearms its flag. The stimulus reaches it in two ways. It holds the dropout input low for the whole rearm write, so the synchronised event is certainly active on that edge. It also drives the timeout pulse on the same falling edge as the clear write. The self-masking of sensed reset is covered too. The bench keeps the sense line low for two cycles after the probe releases its drive, which mimics a slow pull-up, and checks that nothing is latched.

// File: rtl/probe_ctl_pkg.sv
package probe_ctl_pkg;
  localparam int unsigned DATA_W = 32;

  localparam int unsigned TRST_B  = 0;
  localparam int unsigned SRST_B  = 1;
  localparam int unsigned PWR_B   = 3;
  localparam int unsigned LED0_B  = 4;
  localparam int unsigned LED1_B  = 5;
  localparam int unsigned SSEEN_B = 6;
  localparam int unsigned DROP_B  = 7;
  localparam int unsigned ADAPT_B = 8;
  localparam int unsigned TOUT_B  = 10;

  localparam logic [DATA_W-1:0] CTRL_MASK =
    (32'd1 << TRST_B) | (32'd1 << SRST_B) | (32'd1 << PWR_B) |
    (32'd1 << LED0_B) | (32'd1 << LED1_B) | (32'd1 << ADAPT_B);

  localparam int unsigned N_FLAGS = 3;
  localparam int unsigned FL_SSEEN = 0;
  localparam int unsigned FL_DROP  = 1;
  localparam int unsigned FL_TOUT  = 2;
endpackage

// File: rtl/probe_sync.sv
module probe_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= {STAGES{RST_VAL}};
    else         sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/probe_sticky.sv
module probe_sticky (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  // event has priority over the clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (evt_i)  flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  AST_STICKY_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i |=> flag_o); // R8
  AST_STICKY_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clr_i) |=> flag_o); // R5
  AST_STICKY_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !evt_i) |=> !flag_o); // R6
endmodule

// File: rtl/probe_srst_blank.sv
module probe_srst_blank #(
  parameter int unsigned BLANK_CYC = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic drive_i,
  output logic mask_o
);
  localparam int unsigned CNT_W = $clog2(BLANK_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BLANK_CYC);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (drive_i)         cnt_q <= CNT_LOAD;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign mask_o = drive_i || (cnt_q != '0);

  AST_BLANK_AFTER_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(drive_i) |-> mask_o); // R9
endmodule

// File: rtl/probe_ctl_reg.sv
module probe_ctl_reg
  import probe_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] SET_OFS = 8'h10,
  parameter logic [ADDR_W-1:0] CLR_OFS = 8'h14,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned BLANK_CYC   = 8,
  parameter logic [31:0] RST_CTRL    = 32'h0000_0008
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  input  logic              srst_sense_ni,
  input  logic              pwr_good_i,
  input  logic              clk_timeout_i,
  output logic              trst_no,
  output logic              srst_oe_no,
  output logic              pwr_en_o,
  output logic [1:0]        led_o,
  output logic              adapt_clk_en_o
);
  localparam logic [DATA_W-1:0] RST_VAL = RST_CTRL & CTRL_MASK;

  logic set_hit, clr_hit;
  logic [DATA_W-1:0] set_bits, clr_bits, ctrl_q;

  assign set_hit  = bus_wr_i && (bus_addr_i == SET_OFS);
  assign clr_hit  = bus_wr_i && (bus_addr_i == CLR_OFS);
  assign set_bits = set_hit ? (bus_wdata_i & CTRL_MASK) : '0;
  assign clr_bits = clr_hit ? (bus_wdata_i & CTRL_MASK) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= RST_VAL;
    else         ctrl_q <= (ctrl_q | set_bits) & ~clr_bits;
  end

  // event inputs
  logic srst_seen_n_s, pwr_good_s, srst_mask;

  probe_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_srst (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(srst_sense_ni), .q_o(srst_seen_n_s));
  probe_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_pwr (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pwr_good_i), .q_o(pwr_good_s));

  probe_srst_blank #(.BLANK_CYC(BLANK_CYC)) u_blank (
    .clk_i(clk_i), .rst_ni(rst_ni), .drive_i(ctrl_q[SRST_B]), .mask_o(srst_mask));

  logic [N_FLAGS-1:0] fl_evt, fl_clr, fl_q;

  assign fl_evt[FL_SSEEN] = !srst_seen_n_s && !srst_mask;
  assign fl_evt[FL_DROP]  = !pwr_good_s;
  assign fl_evt[FL_TOUT]  = clk_timeout_i;
  assign fl_clr[FL_SSEEN] = set_hit && bus_wdata_i[SSEEN_B];
  assign fl_clr[FL_DROP]  = set_hit && bus_wdata_i[DROP_B];
  assign fl_clr[FL_TOUT]  = clr_hit && bus_wdata_i[TOUT_B];

  for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
    probe_sticky u_flag (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .evt_i(fl_evt[g]), .clr_i(fl_clr[g]), .flag_o(fl_q[g]));
  end

  logic [DATA_W-1:0] status;
  always_comb begin
    status          = ctrl_q;
    status[SSEEN_B] = fl_q[FL_SSEEN];
    status[DROP_B]  = fl_q[FL_DROP];
    status[TOUT_B]  = fl_q[FL_TOUT];
  end

  assign bus_rdata_o    = (bus_addr_i == SET_OFS) ? status : '0;
  assign trst_no        = ~ctrl_q[TRST_B];
  assign srst_oe_no     = ~ctrl_q[SRST_B];
  assign pwr_en_o       = ctrl_q[PWR_B];
  assign led_o          = {ctrl_q[LED1_B], ctrl_q[LED0_B]};
  assign adapt_clk_en_o = ctrl_q[ADAPT_B];

  AST_SET_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_hit |=> ((ctrl_q & $past(bus_wdata_i & CTRL_MASK)) == $past(bus_wdata_i & CTRL_MASK))); // R2
  AST_CLR_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_hit |=> ((ctrl_q & $past(bus_wdata_i & CTRL_MASK)) == '0)); // R3
  AST_NO_STRAY_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(set_hit || clr_hit) |=> $stable(ctrl_q)); // R10
  AST_SRST_SELF_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !srst_oe_no |-> !fl_evt[FL_SSEEN]); // R9
endmodule

// File: tb/probe_ctl_reg_tb_top.sv
`timescale 1ns/1ps
module probe_ctl_reg_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [7:0] bus_addr = 8'h10;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic srst_sense_n = 1'b1, pwr_good = 1'b1, clk_timeout = 1'b0;
  logic trst_n, srst_oe_n, pwr_en, adapt_en;
  logic [1:0] led;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  probe_ctl_reg dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(bus_wr), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .srst_sense_ni(srst_sense_n),
    .pwr_good_i(pwr_good), .clk_timeout_i(clk_timeout), .trst_no(trst_n),
    .srst_oe_no(srst_oe_n), .pwr_en_o(pwr_en), .led_o(led), .adapt_clk_en_o(adapt_en));

  typedef struct packed { logic is_rd; logic [7:0] addr; logic [31:0] data; } vec_t;
  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 8'h10, 32'h0000_0008},  // R1
    '{1'b0, 8'h10, 32'h0000_0031},  // R2
    '{1'b1, 8'h10, 32'h0000_0039},
    '{1'b0, 8'h14, 32'h0000_0008},  // R3
    '{1'b1, 8'h10, 32'h0000_0031},
    '{1'b0, 8'h10, 32'hFFFF_FFFF},  // R10 unused/sticky bits ignored
    '{1'b1, 8'h10, 32'h0000_013B},
    '{1'b1, 8'h14, 32'h0000_0000},
    '{1'b0, 8'h20, 32'hFFFF_FFFF},
    '{1'b1, 8'h10, 32'h0000_013B},
    '{1'b1, 8'h20, 32'h0000_0000},
    '{1'b0, 8'h14, 32'h0000_0102},
    '{1'b1, 8'h10, 32'h0000_0039}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0; bus_addr = 8'h10;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk); bus_addr = a; #1;
    chk(req, bus_rdata, exp);
    bus_addr = 8'h10;
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    wait_cyc(3); rst_n = 1'b1; wait_cyc(1);
    chk("R1 outputs", {27'd0, trst_n, srst_oe_n, pwr_en, led, adapt_en}, {27'd0, 1'b1, 1'b1, 1'b1, 2'b00, 1'b0});

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].is_rd) rd_chk("R2/R3/R10 table", VEC[i].addr, VEC[i].data);
      else              wr(VEC[i].addr, VEC[i].data);
    end

    wr(8'h10, 32'h0000_013B);
    #1;
    chk("R4 outputs", {27'd0, trst_n, srst_oe_n, pwr_en, led, adapt_en}, {27'd0, 1'b0, 1'b0, 1'b1, 2'b11, 1'b1});
    wr(8'h14, 32'hFFFF_FFFF);
    #1;
    chk("R4 outputs cleared", {27'd0, trst_n, srst_oe_n, pwr_en, led, adapt_en}, {27'd0, 1'b1, 1'b1, 1'b0, 2'b00, 1'b0});
    wait_cyc(12);

    // R5 sensed reset
    srst_sense_n = 1'b0; wait_cyc(5); srst_sense_n = 1'b1; wait_cyc(5);
    rd_chk("R5 flag set", 8'h10, 32'h0000_0040);
    wr(8'h14, 32'h0000_0040);
    rd_chk("R10 clear addr ignores bit6", 8'h10, 32'h0000_0040);
    wr(8'h10, 32'h0000_0040);
    rd_chk("R5 rearm", 8'h10, 32'h0000_0000);

    // R9 self-masking
    wr(8'h10, 32'h0000_0002);
    srst_sense_n = 1'b0; wait_cyc(10);
    wr(8'h14, 32'h0000_0002);
    wait_cyc(1); srst_sense_n = 1'b1; wait_cyc(12);
    rd_chk("R9 own reset ignored", 8'h10, 32'h0000_0000);

    // R6 dropout
    pwr_good = 1'b0; wait_cyc(4); pwr_good = 1'b1; wait_cyc(5);
    rd_chk("R6 flag set", 8'h10, 32'h0000_0080);
    wr(8'h14, 32'h0000_0080);
    rd_chk("R10 clear addr ignores bit7", 8'h10, 32'h0000_0080);
    wr(8'h10, 32'h0000_0080);
    rd_chk("R6 rearm", 8'h10, 32'h0000_0000);

    // R7 timeout
    @(negedge clk); clk_timeout = 1'b1; @(negedge clk); clk_timeout = 1'b0;
    rd_chk("R7 flag set", 8'h10, 32'h0000_0400);
    wr(8'h10, 32'h0000_0400);
    rd_chk("R10 set addr ignores bit10", 8'h10, 32'h0000_0400);
    wr(8'h14, 32'h0000_0400);
    rd_chk("R7 cleared", 8'h10, 32'h0000_0000);

    // R8 event beats rearm/clear
    pwr_good = 1'b0; wait_cyc(5);
    wr(8'h10, 32'h0000_0080);
    rd_chk("R8 dropout held over rearm", 8'h10, 32'h0000_0080);
    pwr_good = 1'b1; wait_cyc(5);
    wr(8'h10, 32'h0000_0080);
    rd_chk("R8 rearm after release", 8'h10, 32'h0000_0000);
    @(negedge clk); clk_timeout = 1'b1; @(negedge clk); clk_timeout = 1'b0;
    @(negedge clk); bus_wr = 1'b1; bus_addr = 8'h14; bus_wdata = 32'h400; clk_timeout = 1'b1;
    @(negedge clk); bus_wr = 1'b0; bus_addr = 8'h10; clk_timeout = 1'b0;
    rd_chk("R8 timeout over clear", 8'h10, 32'h0000_0400);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    wait_cyc(20000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule